// File: doc/BRIEF.md
# Handler Entry Annotation Tracker

This block annotates a stream of retiring instructions with the reason a handler was entered. The surrounding core reports three kinds of entry event with single-cycle strobes: entry into debug mode, entry into a trap handler because of a synchronous exception, and entry into a trap handler because of an interrupt. Each strobe comes with its cause value. Detecting causes and updating control registers happen elsewhere. Entry events are treated as happening between instructions. The block holds each event as a pending record and attaches it to the next instruction that retires.

For every retirement the block produces one annotation, registered one cycle after the retire strobe. The annotation has a 3-bit debug cause, a flag that tells whether the instruction executed in debug mode, and a 14-bit handler-entry record. A debug entry that arrives while a trap handler is still waiting for its first instruction does not cancel the trap record. That first handler instruction then carries both the debug cause and the handler-entry record.

Top module: `hentry_tracker`

## Requirements
- R1: `out_valid` is high exactly one cycle after each cycle in which `retire_valid` is high. Whenever `out_valid` is low, `out_dbg_cause`, `out_dbg_mode` and `out_intr` are all zero.
- R2: The debug cause encoding is 0 none, 1 breakpoint instruction, 2 trigger match, 3 external request, 4 single step. The cause given with a debug entry strobe appears on the first retirement after that strobe. Every other retirement reports cause 0.
- R3: A debug entry strobe sets the debug-mode state and a resume strobe clears it. Entry wins if both strobes occur in the same cycle. A retirement reports the mode that held before the strobes of its own cycle, so a retirement in the same cycle as a resume still reports 1.
- R4: `out_intr` bit 0 is intr, bit 1 is exception, bit 2 is interrupt, and bits 13:3 are the 11-bit cause. A trap entry produces intr=1, exception=1, interrupt=0 with the trap cause. An interrupt entry produces intr=1, exception=0, interrupt=1 with the interrupt cause.
- R5: A debug entry on its own leaves `out_intr` zero. A debug entry that arrives after a trap or interrupt entry and before the next retirement is reported on the same retirement as the handler-entry record.
- R6: A debug entry strobe while already in debug mode (a breakpoint inside the debug handler) is reported like any other, with its cause (1) on the next retirement.
- R7: A pending record is held for any number of cycles without a retirement. It is cleared once it has been reported.
- R8: An entry strobe in the same cycle as a retirement does not annotate that retirement. It is attached to the next one.
- R9: Trap entry and interrupt entry share one pending record. A later strobe of either kind overwrites the pending cause, and a later debug entry overwrites the pending debug cause. If trap and interrupt strobes occur in the same cycle, the interrupt record is kept.
- R10: After reset, nothing is pending, the debug-mode state is 0 and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_valid | input | 1 | An instruction retires this cycle |
| dbg_entry | input | 1 | Debug mode entered this cycle |
| dbg_cause_in | input | 3 | Cause of the debug entry |
| dbg_resume | input | 1 | Debug mode left this cycle |
| trap_entry | input | 1 | Synchronous trap handler entered this cycle |
| trap_cause | input | 11 | Exception cause |
| irq_entry | input | 1 | Interrupt handler entered this cycle |
| irq_cause | input | 11 | Interrupt cause |
| out_valid | output | 1 | Annotation valid (retirement one cycle earlier) |
| out_dbg_cause | output | 3 | Debug cause for that retirement |
| out_dbg_mode | output | 1 | Retirement executed in debug mode |
| out_intr | output | 14 | Handler-entry record {cause, interrupt, exception, intr} |

## Verification
The bench steps each debug cause through entry, idle gaps and later retirements. This separates reporting once from reporting repeatedly, and shows that holding across idle cycles works. Trap and interrupt causes are swept across the 11-bit range, including the all-ones code, to prove the field position and the flag bits. Mixed patterns place a debug entry behind a trap entry, put two events of one kind before a retirement, strobe trap and interrupt together, and strobe an event in the same cycle as a retirement. These patterns tell apart merge, overwrite, priority and attach-to-next behaviour. Resume cycles with retirement, and a breakpoint inside debug mode, expose the timing of the mode flag.

// File: rtl/hentry_pkg.sv
package hentry_pkg;
  localparam int DBG_CAUSE_W = 3;
  localparam int CAUSE_W     = 11;
  localparam int REC_W       = CAUSE_W + 3;

  typedef struct packed {
    logic [CAUSE_W-1:0] cause;
    logic               interrupt;
    logic               exception;
    logic               intr;
  } intr_rec_t;

  function automatic intr_rec_t make_trap_rec(input logic [CAUSE_W-1:0] c);
    intr_rec_t r;
    r.cause     = c;
    r.interrupt = 1'b0;
    r.exception = 1'b1;
    r.intr      = 1'b1;
    return r;
  endfunction

  function automatic intr_rec_t make_irq_rec(input logic [CAUSE_W-1:0] c);
    intr_rec_t r;
    r.cause     = c;
    r.interrupt = 1'b1;
    r.exception = 1'b0;
    r.intr      = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/hentry_intr_pend.sv
module hentry_intr_pend
  import hentry_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               consume,
  input  logic               trap_ev,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic               irq_ev,
  input  logic [CAUSE_W-1:0] irq_cause,
  output intr_rec_t          rec
);
  // Newest event wins over the clear; interrupt wins over trap.
  always_ff @(posedge clk) begin
    if (!rst_n)       rec <= '0;
    else if (irq_ev)  rec <= make_irq_rec(irq_cause);
    else if (trap_ev) rec <= make_trap_rec(trap_cause);
    else if (consume) rec <= '0;
  end
endmodule

// File: rtl/hentry_dbg_track.sv
module hentry_dbg_track
  import hentry_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   consume,
  input  logic                   entry,
  input  logic [DBG_CAUSE_W-1:0] cause_in,
  input  logic                   resume,
  output logic [DBG_CAUSE_W-1:0] pend_cause,
  output logic                   mode
);
  always_ff @(posedge clk) begin
    if (!rst_n)       pend_cause <= '0;
    else if (entry)   pend_cause <= cause_in;
    else if (consume) pend_cause <= '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      mode <= 1'b0;
    else if (entry)  mode <= 1'b1;
    else if (resume) mode <= 1'b0;
  end
endmodule

// File: rtl/hentry_tracker.sv
module hentry_tracker
  import hentry_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   retire_valid,
  input  logic                   dbg_entry,
  input  logic [DBG_CAUSE_W-1:0] dbg_cause_in,
  input  logic                   dbg_resume,
  input  logic                   trap_entry,
  input  logic [CAUSE_W-1:0]     trap_cause,
  input  logic                   irq_entry,
  input  logic [CAUSE_W-1:0]     irq_cause,
  output logic                   out_valid,
  output logic [DBG_CAUSE_W-1:0] out_dbg_cause,
  output logic                   out_dbg_mode,
  output logic [REC_W-1:0]       out_intr
);
  intr_rec_t              pend_rec;
  logic [DBG_CAUSE_W-1:0] pend_dbg;
  logic                   cur_mode;
  logic                   report_fire;

  assign report_fire = retire_valid;

  hentry_intr_pend u_intr (
    .clk        (clk),
    .rst_n      (rst_n),
    .consume    (report_fire),
    .trap_ev    (trap_entry),
    .trap_cause (trap_cause),
    .irq_ev     (irq_entry),
    .irq_cause  (irq_cause),
    .rec        (pend_rec)
  );

  hentry_dbg_track u_dbg (
    .clk        (clk),
    .rst_n      (rst_n),
    .consume    (report_fire),
    .entry      (dbg_entry),
    .cause_in   (dbg_cause_in),
    .resume     (dbg_resume),
    .pend_cause (pend_dbg),
    .mode       (cur_mode)
  );

  // Annotation uses state from before this cycle's strobes.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_dbg_cause <= '0;
      out_dbg_mode  <= 1'b0;
      out_intr      <= '0;
    end else begin
      out_valid     <= report_fire;
      out_dbg_cause <= report_fire ? pend_dbg : '0;
      out_dbg_mode  <= report_fire & cur_mode;
      out_intr      <= report_fire ? REC_W'(pend_rec) : '0;
    end
  end
endmodule

// File: rtl/hentry_tracker_chk.sv
module hentry_tracker_chk
  import hentry_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   retire_valid,
  input logic                   dbg_entry,
  input logic [DBG_CAUSE_W-1:0] dbg_cause_in,
  input logic                   dbg_resume,
  input logic                   trap_entry,
  input logic [CAUSE_W-1:0]     trap_cause,
  input logic                   irq_entry,
  input logic [CAUSE_W-1:0]     irq_cause,
  input logic                   out_valid,
  input logic [DBG_CAUSE_W-1:0] out_dbg_cause,
  input logic                   out_dbg_mode,
  input logic [REC_W-1:0]       out_intr
);
  assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_intr == '0 && out_dbg_cause == '0 && !out_dbg_mode));

  assert_dbg_cause_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && !dbg_entry) ##1 retire_valid |=> out_dbg_cause == '0);

  assert_dbg_entry_reported_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_entry ##1 retire_valid |=> (out_dbg_mode && out_dbg_cause == $past(dbg_cause_in, 2)));

  assert_rec_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($onehot0(out_intr[2:1]) && (out_intr[0] == |out_intr[2:1])));

  assert_trap_record_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_entry && !irq_entry) ##1 retire_valid |=>
      (out_intr[2:0] == 3'b011 && out_intr[REC_W-1:3] == $past(trap_cause, 2)));

  assert_rec_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && !trap_entry && !irq_entry) ##1 retire_valid |=> out_intr == '0);
endmodule

bind hentry_tracker hentry_tracker_chk u_chk (.*);

// File: tb/hentry_tracker_test.sv
module hentry_tracker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        retire_valid = 1'b0;
  logic        dbg_entry = 1'b0;
  logic [2:0]  dbg_cause_in = '0;
  logic        dbg_resume = 1'b0;
  logic        trap_entry = 1'b0;
  logic [10:0] trap_cause = '0;
  logic        irq_entry = 1'b0;
  logic [10:0] irq_cause = '0;
  logic        out_valid;
  logic [2:0]  out_dbg_cause;
  logic        out_dbg_mode;
  logic [13:0] out_intr;

  int checks = 0;
  int errors = 0;

  logic [2:0]  m_dc = '0;
  logic        m_mode = 1'b0;
  logic [13:0] m_rec = '0;

  always #4 clk = ~clk;

  hentry_tracker uut (.*);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic tick(input bit r, input bit de, input logic [2:0] dc, input bit rs,
                      input bit te, input logic [10:0] tc, input bit ie,
                      input logic [10:0] icc, input string tag);
    bit          e_v;
    logic [2:0]  e_dc;
    bit          e_m;
    logic [13:0] e_i;
    retire_valid = r; dbg_entry = de; dbg_cause_in = dc; dbg_resume = rs;
    trap_entry = te; trap_cause = tc; irq_entry = ie; irq_cause = icc;
    e_v  = r;
    e_dc = r ? m_dc : 3'd0;
    e_m  = r ? m_mode : 1'b0;
    e_i  = r ? m_rec : 14'd0;
    if (r) begin m_dc = '0; m_rec = '0; end
    if (de) m_dc = dc;
    if (ie) m_rec = 14'(int'(icc) * 8 + 5);
    else if (te) m_rec = 14'(int'(tc) * 8 + 3);
    if (de) m_mode = 1'b1;
    else if (rs) m_mode = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "valid", int'(out_valid), int'(e_v));
    chk(tag, "dbg_cause", int'(out_dbg_cause), int'(e_dc));
    chk(tag, "dbg_mode", int'(out_dbg_mode), int'(e_m));
    chk(tag, "intr", int'(out_intr), int'(e_i));
  endtask

  task automatic idle(input string tag);
    tick(0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic ret(input string tag);
    tick(1, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state
    chk("R10", "valid", int'(out_valid), 0);
    chk("R10", "intr", int'(out_intr), 0);
    ret("R10");
    idle("R1");
    // R2, R7: each debug cause held across gaps, reported once
    for (int c = 1; c <= 4; c++) begin
      tick(0, 1, 3'(c), 0, 0, 0, 0, 0, "R2");
      idle("R7");
      idle("R7");
      ret("R2");
      ret("R2");
      tick(1, 0, 0, 1, 0, 0, 0, 0, "R3");
      ret("R3");
    end
    // R6: breakpoint inside debug mode
    tick(0, 1, 3'd3, 0, 0, 0, 0, 0, "R6");
    ret("R6");
    tick(0, 1, 3'd1, 0, 0, 0, 0, 0, "R6");
    ret("R6");
    tick(1, 0, 0, 1, 0, 0, 0, 0, "R3");
    // R3: entry and resume together, entry wins
    tick(0, 1, 3'd4, 1, 0, 0, 0, 0, "R3");
    ret("R3");
    tick(0, 0, 0, 1, 0, 0, 0, 0, "R3");
    ret("R3");
    // R4: sweep trap and interrupt causes
    for (int c = 0; c < 2048; c += 97) begin
      tick(0, 0, 0, 0, 1, 11'(c), 0, 0, "R4");
      ret("R4");
      ret("R4");
    end
    for (int c = 5; c < 2048; c += 131) begin
      tick(0, 0, 0, 0, 0, 0, 1, 11'(c), "R4");
      idle("R7");
      ret("R4");
    end
    tick(0, 0, 0, 0, 0, 0, 1, 11'h7FF, "R4");
    ret("R4");
    tick(0, 0, 0, 0, 1, 11'h7FF, 0, 0, "R4");
    ret("R4");
    // R5: debug alone, then debug behind a trap
    tick(0, 1, 3'd2, 0, 0, 0, 0, 0, "R5");
    ret("R5");
    tick(1, 0, 0, 1, 0, 0, 0, 0, "R5");
    tick(0, 0, 0, 0, 1, 11'd2, 0, 0, "R5");
    tick(0, 1, 3'd4, 0, 0, 0, 0, 0, "R5");
    ret("R5");
    ret("R5");
    tick(1, 0, 0, 1, 0, 0, 0, 0, "R5");
    // R8: events in the same cycle as a retirement
    tick(1, 1, 3'd2, 0, 1, 11'd7, 0, 0, "R8");
    ret("R8");
    tick(1, 0, 0, 1, 0, 0, 1, 11'd11, "R8");
    ret("R8");
    // R9: overwrite and same-cycle priority
    tick(0, 0, 0, 0, 1, 11'd3, 0, 0, "R9");
    tick(0, 0, 0, 0, 0, 0, 1, 11'd9, "R9");
    ret("R9");
    tick(0, 0, 0, 0, 0, 0, 1, 11'd9, "R9");
    tick(0, 0, 0, 0, 1, 11'd13, 0, 0, "R9");
    ret("R9");
    tick(0, 0, 0, 0, 1, 11'd5, 1, 11'd21, "R9");
    ret("R9");
    tick(0, 1, 3'd2, 0, 0, 0, 0, 0, "R9");
    tick(0, 1, 3'd3, 0, 0, 0, 0, 0, "R9");
    ret("R9");
    tick(1, 0, 0, 1, 0, 0, 0, 0, "R9");
    idle("R1");
    ret("R1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule